// File: doc/BRIEF.md
# Adaptive Least-Cost Neighbour Selector

This block sits inside one router of an on-chip network and decides which neighbouring router an outgoing packet is handed to. It keeps a table of learned delivery-cost estimates, one row per destination and one column per neighbour port. A routing request names a destination, and the block answers with the neighbour whose estimate is lowest among the links currently usable. Now and then, at a programmable rate, it answers with a pseudo-randomly chosen usable neighbour instead. This exploration keeps stale estimates from locking traffic onto one path.

When a neighbour returns its own best estimate for a destination, the block moves its table entry for that destination and neighbour part of the way towards that value plus a fixed per-hop cost. A separate query port reports the block's own best estimate for a destination, which the router sends back to its upstream neighbours as feedback. Ports flagged in a diagonal mask win cost ties over straight ports.

A two-state controller governs the block. FILL is entered at reset. The FILL-to-FILL transition loads one table row per cycle with the start cost, and the FILL-to-SERVE transition is taken after the last row is loaded. SERVE-to-SERVE is the only transition out of SERVE: in that state the block answers requests and queries and accepts learning updates.

Top module: `qroute_selector`

## Requirements
- R1: After reset is released, `ready` stays 0 for exactly NUM_DEST (default 4) clock edges and then stays 1. Every table entry then holds INIT_COST (default 16).
- R2: A request accepted while `ready` is 1 produces `resp_valid` high for exactly one cycle, on the clock edge that samples the request.
- R3: When exploration is not taken, `resp_port` is the usable neighbour with the lowest table entry for `req_dest`.
- R4: Among neighbours with equal cost, a diagonal port beats a straight port, and within the same class the lower port index wins. Diagonal ports are given by DIAG_MASK, default 8'hF0 (ports 4 to 7).
- R5: A neighbour whose bit in `link_valid` is 0 is never reported, either by the least-cost search or by exploration.
- R6: A learning update for (dest, port) with returned cost c sets the entry to old + ((min(c + LINK_DELAY, 2^COST_W - 1) - old) >>> LEARN_SHIFT). The shift is arithmetic (it rounds toward minus infinity), and the result is clamped to the unsigned cost range. Defaults are LINK_DELAY 1 and LEARN_SHIFT 1.
- R7: When an update and a request or query for the same destination share a cycle, the answer is computed from the updated entry.
- R8: Exploration is taken when the low byte of the internal 16-bit pseudo-random register is below `epsilon`. `epsilon` = 0 never explores. An explored answer sets `resp_explore` to 1, and with `epsilon` = 255 nearly every request explores.
- R9: An accepted query produces `qry_ack` one edge later, with `qry_cost` equal to the lowest entry among usable neighbours for `qry_dest`. If no link is usable, `qry_cost` is all ones.
- R10: If no link is usable, a request is still answered, with `resp_none` = 1.
- R11: Requests made while `ready` is 0 are dropped: no `resp_valid` follows them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| link_valid | input | NUM_NBR | Usable-neighbour mask |
| epsilon | input | 8 | Exploration threshold |
| ready | output | 1 | Table loaded, requests accepted |
| req_valid | input | 1 | Routing request strobe |
| req_dest | input | DEST_W | Destination of the request |
| resp_valid | output | 1 | Routing answer strobe |
| resp_port | output | PORT_W | Chosen neighbour port |
| resp_explore | output | 1 | Answer came from exploration |
| resp_none | output | 1 | No usable neighbour existed |
| upd_valid | input | 1 | Learning update strobe |
| upd_dest | input | DEST_W | Destination of the update |
| upd_port | input | PORT_W | Neighbour that sent the update |
| upd_cost | input | COST_W | Neighbour's own best estimate |
| qry_valid | input | 1 | Own-estimate query strobe |
| qry_dest | input | DEST_W | Destination queried |
| qry_ack | output | 1 | Query answer strobe |
| qry_cost | output | COST_W | Own best estimate |

## Verification
A learning update and a lookup, whether a routing request or an estimate query, can land on the same table entry in the same cycle. The bench provokes this on a fresh destination. Two usable ports start tied, so the lower port would win. In the same cycle as a request and a query for that destination, an update drives the other port's entry below the tie. The answer is judged correct only if it names the updated port and reports the post-update cost, which rules out a read of the stale entry.

// File: rtl/qrs_pkg.sv
package qrs_pkg;
    typedef enum logic [0:0] {
        ST_FILL  = 1'b0,
        ST_SERVE = 1'b1
    } qrs_state_e;

    localparam int LFSR_W = 16;
endpackage

// File: rtl/qrs_cost_table.sv
module qrs_cost_table #(
    parameter int NUM_DEST    = 4,
    parameter int NUM_NBR     = 8,
    parameter int COST_W      = 8,
    parameter int INIT_COST   = 16,
    parameter int LINK_DELAY  = 1,
    parameter int LEARN_SHIFT = 1,
    parameter int DEST_W      = 2,
    parameter int PORT_W      = 3
) (
    input  logic                      clk,
    input  logic                      fill_en,
    input  logic [DEST_W-1:0]         fill_row,
    input  logic                      upd_en,
    input  logic [DEST_W-1:0]         upd_dest,
    input  logic [PORT_W-1:0]         upd_port,
    input  logic [COST_W-1:0]         upd_cost,
    input  logic [DEST_W-1:0]         rd_a_dest,
    input  logic [DEST_W-1:0]         rd_b_dest,
    output logic [NUM_NBR*COST_W-1:0] rd_a_row,
    output logic [NUM_NBR*COST_W-1:0] rd_b_row
);
    localparam int EW = COST_W + 2;
    localparam logic [COST_W-1:0] CMAX = {COST_W{1'b1}};
    localparam logic [COST_W-1:0] CINIT = COST_W'(INIT_COST);

    logic [COST_W-1:0] cell_q [NUM_DEST][NUM_NBR];

    logic [COST_W:0]        tgt_wide;
    logic [COST_W-1:0]      tgt;
    logic [COST_W-1:0]      old_val;
    logic signed [EW-1:0]   delta;
    logic signed [EW-1:0]   step;
    logic signed [EW-1:0]   sum;
    logic [COST_W-1:0]      new_val;

    always_comb begin
        tgt_wide = {1'b0, upd_cost} + (COST_W+1)'(LINK_DELAY);
        tgt      = tgt_wide[COST_W] ? CMAX : tgt_wide[COST_W-1:0];
        old_val  = cell_q[upd_dest][upd_port];
        delta    = $signed({2'b00, tgt}) - $signed({2'b00, old_val});
        step     = delta >>> LEARN_SHIFT;
        sum      = $signed({2'b00, old_val}) + step;
        if (sum < 0)
            new_val = '0;
        else if (sum > $signed({2'b00, CMAX}))
            new_val = CMAX;
        else
            new_val = sum[COST_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            for (int p = 0; p < NUM_NBR; p++)
                cell_q[fill_row][p] <= CINIT;
        end else if (upd_en) begin
            cell_q[upd_dest][upd_port] <= new_val;
        end
    end

    for (genvar p = 0; p < NUM_NBR; p++) begin : g_fwd
        logic hit_a, hit_b;
        assign hit_a = upd_en && (upd_dest == rd_a_dest) && (upd_port == PORT_W'(p));
        assign hit_b = upd_en && (upd_dest == rd_b_dest) && (upd_port == PORT_W'(p));
        assign rd_a_row[p*COST_W +: COST_W] = hit_a ? new_val : cell_q[rd_a_dest][p];
        assign rd_b_row[p*COST_W +: COST_W] = hit_b ? new_val : cell_q[rd_b_dest][p];
    end
endmodule

// File: rtl/qrs_min_pick.sv
module qrs_min_pick #(
    parameter int               NUM_NBR   = 8,
    parameter int               COST_W    = 8,
    parameter int               PORT_W    = 3,
    parameter logic [NUM_NBR-1:0] DIAG_MASK = '0
) (
    input  logic [NUM_NBR*COST_W-1:0] row,
    input  logic [NUM_NBR-1:0]        mask,
    output logic                      found,
    output logic [PORT_W-1:0]         best_port,
    output logic [COST_W-1:0]         best_cost
);
    always_comb begin
        found     = 1'b0;
        best_port = '0;
        best_cost = '1;
        for (int p = 0; p < NUM_NBR; p++) begin
            if (mask[p]) begin
                if (!found
                    || row[p*COST_W +: COST_W] < best_cost
                    || (row[p*COST_W +: COST_W] == best_cost
                        && DIAG_MASK[p] && !DIAG_MASK[best_port])) begin
                    found     = 1'b1;
                    best_port = PORT_W'(p);
                    best_cost = row[p*COST_W +: COST_W];
                end
            end
        end
    end
endmodule

// File: rtl/qrs_explore.sv
module qrs_explore #(
    parameter int          NUM_NBR   = 8,
    parameter int          PORT_W    = 3,
    parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         epsilon,
    input  logic [NUM_NBR-1:0] mask,
    output logic               take,
    output logic               found,
    output logic [PORT_W-1:0]  port
);
    import qrs_pkg::*;

    logic [LFSR_W-1:0] lfsr_q;
    logic              fb;

    assign fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lfsr_q <= LFSR_SEED;
        else
            lfsr_q <= {lfsr_q[14:0], fb};
    end

    assign take = lfsr_q[7:0] < epsilon;

    always_comb begin
        int start;
        int idx;
        found = 1'b0;
        port  = '0;
        start = int'(lfsr_q[8 +: PORT_W]) % NUM_NBR;
        for (int k = 0; k < NUM_NBR; k++) begin
            idx = start + k;
            if (idx >= NUM_NBR)
                idx = idx - NUM_NBR;
            if (!found && mask[idx]) begin
                found = 1'b1;
                port  = PORT_W'(idx);
            end
        end
    end
endmodule

// File: rtl/qroute_selector.sv
module qroute_selector #(
    parameter int          NUM_DEST    = 4,
    parameter int          NUM_NBR     = 8,
    parameter int          COST_W      = 8,
    parameter int          INIT_COST   = 16,
    parameter int          LINK_DELAY  = 1,
    parameter int          LEARN_SHIFT = 1,
    parameter logic [NUM_NBR-1:0] DIAG_MASK = NUM_NBR'(8'hF0),
    parameter logic [15:0] LFSR_SEED   = 16'hACE1,
    localparam int DEST_W = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1,
    localparam int PORT_W = (NUM_NBR > 1) ? $clog2(NUM_NBR) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_NBR-1:0] link_valid,
    input  logic [7:0]         epsilon,
    output logic               ready,
    input  logic               req_valid,
    input  logic [DEST_W-1:0]  req_dest,
    output logic               resp_valid,
    output logic [PORT_W-1:0]  resp_port,
    output logic               resp_explore,
    output logic               resp_none,
    input  logic               upd_valid,
    input  logic [DEST_W-1:0]  upd_dest,
    input  logic [PORT_W-1:0]  upd_port,
    input  logic [COST_W-1:0]  upd_cost,
    input  logic               qry_valid,
    input  logic [DEST_W-1:0]  qry_dest,
    output logic               qry_ack,
    output logic [COST_W-1:0]  qry_cost
);
    import qrs_pkg::*;

    localparam logic [DEST_W-1:0] LAST_ROW = DEST_W'(NUM_DEST - 1);

    qrs_state_e        state_q, state_d;
    logic [DEST_W-1:0] row_q, row_d;

    logic fill_en, upd_en, req_acc, qry_acc;

    logic [NUM_NBR*COST_W-1:0] req_row, qry_row;
    logic                      g_found, q_found, x_take, x_found;
    logic [PORT_W-1:0]         g_port, q_port_unused, x_port;
    logic [COST_W-1:0]         g_cost_unused, q_cost;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        row_d   = row_q;
        unique case (state_q)
            ST_FILL: begin
                if (row_q == LAST_ROW) begin
                    state_d = ST_SERVE;
                    row_d   = '0;
                end else begin
                    row_d = row_q + 1'b1;
                end
            end
            ST_SERVE: begin
                state_d = ST_SERVE;
            end
            default: state_d = ST_FILL;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            row_q   <= row_d;
        end
    end

    assign ready   = (state_q == ST_SERVE);
    assign fill_en = (state_q == ST_FILL);
    assign upd_en  = upd_valid && ready;
    assign req_acc = req_valid && ready;
    assign qry_acc = qry_valid && ready;

    qrs_cost_table #(
        .NUM_DEST(NUM_DEST), .NUM_NBR(NUM_NBR), .COST_W(COST_W),
        .INIT_COST(INIT_COST), .LINK_DELAY(LINK_DELAY),
        .LEARN_SHIFT(LEARN_SHIFT), .DEST_W(DEST_W), .PORT_W(PORT_W)
    ) u_table (
        .clk(clk), .fill_en(fill_en), .fill_row(row_q),
        .upd_en(upd_en), .upd_dest(upd_dest), .upd_port(upd_port),
        .upd_cost(upd_cost), .rd_a_dest(req_dest), .rd_b_dest(qry_dest),
        .rd_a_row(req_row), .rd_b_row(qry_row)
    );

    qrs_min_pick #(
        .NUM_NBR(NUM_NBR), .COST_W(COST_W), .PORT_W(PORT_W), .DIAG_MASK(DIAG_MASK)
    ) u_pick_req (
        .row(req_row), .mask(link_valid), .found(g_found),
        .best_port(g_port), .best_cost(g_cost_unused)
    );

    qrs_min_pick #(
        .NUM_NBR(NUM_NBR), .COST_W(COST_W), .PORT_W(PORT_W), .DIAG_MASK(DIAG_MASK)
    ) u_pick_qry (
        .row(qry_row), .mask(link_valid), .found(q_found),
        .best_port(q_port_unused), .best_cost(q_cost)
    );

    qrs_explore #(
        .NUM_NBR(NUM_NBR), .PORT_W(PORT_W), .LFSR_SEED(LFSR_SEED)
    ) u_explore (
        .clk(clk), .rst_n(rst_n), .epsilon(epsilon), .mask(link_valid),
        .take(x_take), .found(x_found), .port(x_port)
    );

    // Output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid   <= 1'b0;
            resp_port    <= '0;
            resp_explore <= 1'b0;
            resp_none    <= 1'b0;
            qry_ack      <= 1'b0;
            qry_cost     <= '1;
        end else begin
            resp_valid <= req_acc;
            qry_ack    <= qry_acc;
            if (req_acc) begin
                resp_none <= !g_found;
                if (x_take && x_found) begin
                    resp_port    <= x_port;
                    resp_explore <= 1'b1;
                end else begin
                    resp_port    <= g_port;
                    resp_explore <= 1'b0;
                end
            end
            if (qry_acc)
                qry_cost <= q_found ? q_cost : '1;
        end
    end
endmodule

// File: rtl/qrs_checker.sv
module qrs_checker #(
    parameter int NUM_NBR = 8,
    localparam int PORT_W = (NUM_NBR > 1) ? $clog2(NUM_NBR) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_NBR-1:0] link_valid,
    input logic [7:0]         epsilon,
    input logic               ready,
    input logic               req_valid,
    input logic               resp_valid,
    input logic [PORT_W-1:0]  resp_port,
    input logic               resp_explore,
    input logic               resp_none,
    input logic               qry_valid,
    input logic               qry_ack
);
    logic [NUM_NBR-1:0] mask_q;
    logic [7:0]         eps_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            eps_q  <= '0;
        end else begin
            mask_q <= link_valid;
            eps_q  <= epsilon;
        end
    end

    a_r1_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> resp_valid);

    a_r11_no_resp_unasked: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && req_valid) |=> !resp_valid);

    a_r5_port_usable: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_none) |-> mask_q[resp_port]);

    a_r8_eps_zero_greedy: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && eps_q == 8'd0) |-> !resp_explore);

    a_r10_none_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && mask_q == '0) |-> resp_none);

    a_r9_query_acked: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && qry_valid) |=> qry_ack);
endmodule

bind qroute_selector qrs_checker #(.NUM_NBR(NUM_NBR)) u_qrs_chk (
    .clk(clk), .rst_n(rst_n), .link_valid(link_valid), .epsilon(epsilon),
    .ready(ready), .req_valid(req_valid), .resp_valid(resp_valid),
    .resp_port(resp_port), .resp_explore(resp_explore), .resp_none(resp_none),
    .qry_valid(qry_valid), .qry_ack(qry_ack)
);

// File: tb/qroute_selector_tb_top.sv
`timescale 1ns/1ps
module qroute_selector_tb_top;
    localparam int ND = 4, NN = 8, CW = 8, INIT = 16, DLY = 1, SH = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NN-1:0] link_valid = '1;
    logic [7:0]    epsilon = '0;
    logic          ready;
    logic          req_valid = 1'b0;
    logic [1:0]    req_dest = '0;
    logic          resp_valid;
    logic [2:0]    resp_port;
    logic          resp_explore;
    logic          resp_none;
    logic          upd_valid = 1'b0;
    logic [1:0]    upd_dest = '0;
    logic [2:0]    upd_port = '0;
    logic [CW-1:0] upd_cost = '0;
    logic          qry_valid = 1'b0;
    logic [1:0]    qry_dest = '0;
    logic          qry_ack;
    logic [CW-1:0] qry_cost;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int model [ND][NN];

    always #4 clk = ~clk;

    qroute_selector dut_i (
        .clk(clk), .rst_n(rst_n), .link_valid(link_valid), .epsilon(epsilon),
        .ready(ready), .req_valid(req_valid), .req_dest(req_dest),
        .resp_valid(resp_valid), .resp_port(resp_port),
        .resp_explore(resp_explore), .resp_none(resp_none),
        .upd_valid(upd_valid), .upd_dest(upd_dest), .upd_port(upd_port),
        .upd_cost(upd_cost), .qry_valid(qry_valid), .qry_dest(qry_dest),
        .qry_ack(qry_ack), .qry_cost(qry_cost)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit is_diag(input int p);
        return p >= 4;
    endfunction

    function automatic void mdl_upd(input int d, input int p, input int c);
        int t, df, st, s;
        t  = (c + DLY > 255) ? 255 : c + DLY;
        df = t - model[d][p];
        st = df >>> SH;
        s  = model[d][p] + st;
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        model[d][p] = s;
    endfunction

    task automatic mdl_best(input int d, input logic [NN-1:0] m,
                            output int bp, output int bc, output bit fnd);
        fnd = 0; bp = 0; bc = 255;
        for (int p = 0; p < NN; p++) begin
            if (m[p]) begin
                if (!fnd || model[d][p] < bc ||
                    (model[d][p] == bc && is_diag(p) && !is_diag(bp))) begin
                    fnd = 1; bp = p; bc = model[d][p];
                end
            end
        end
    endtask

    task automatic do_update(input int d, input int p, input int c);
        @(negedge clk);
        upd_valid = 1'b1; upd_dest = 2'(d); upd_port = 3'(p); upd_cost = 8'(c);
        @(posedge clk);
        @(negedge clk);
        upd_valid = 1'b0;
        mdl_upd(d, p, c);
    endtask

    // Request and query for d in one cycle; outputs sampled after the edge.
    task automatic probe(input int d);
        @(negedge clk);
        req_valid = 1'b1; req_dest = 2'(d);
        qry_valid = 1'b1; qry_dest = 2'(d);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; qry_valid = 1'b0;
    endtask

    task automatic greedy_check(input int d, input string tag);
        int bp, bc;
        bit fnd;
        mdl_best(d, link_valid, bp, bc, fnd);
        probe(d);
        chk(resp_valid == 1'b1, {tag, " resp_valid"}, int'(resp_valid), 1);
        chk(resp_none == !fnd, {tag, " resp_none"}, int'(resp_none), int'(!fnd));
        if (fnd)
            chk(int'(resp_port) == bp, {tag, " port"}, int'(resp_port), bp);
        chk(int'(qry_cost) == (fnd ? bc : 255), {tag, " R9 qry_cost"},
            int'(qry_cost), fnd ? bc : 255);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int cyc, n_expl, bp, bc;
        bit fnd;
        logic [NN-1:0] masks [6];
        masks[0] = 8'hFF; masks[1] = 8'h0F; masks[2] = 8'hF0;
        masks[3] = 8'h81; masks[4] = 8'h01; masks[5] = 8'h00;
        for (int d = 0; d < ND; d++)
            for (int p = 0; p < NN; p++)
                model[d][p] = INIT;

        repeat (3) @(negedge clk);
        chk(ready == 1'b0 && resp_valid == 1'b0 && qry_ack == 1'b0,
            "R1 reset state", int'(ready), 0);
        rst_n = 1'b1;
        // R11: request held during fill must be dropped
        req_valid = 1'b1;
        cyc = 0;
        while (!ready && cyc < 50) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
            if (!ready)
                chk(resp_valid == 1'b0, "R11 no resp while filling", int'(resp_valid), 0);
        end
        req_valid = 1'b0;
        chk(cyc == ND, "R1 fill length", cyc, ND);
        @(posedge clk);
        @(negedge clk);
        chk(resp_valid == 1'b0, "R11 dropped request", int'(resp_valid), 0);
        chk(ready == 1'b1, "R1 ready holds", int'(ready), 1);

        // R1/R4: fresh table, all ties
        link_valid = 8'hFF; epsilon = 8'd0;
        probe(0);
        chk(int'(qry_cost) == INIT, "R1 init cost", int'(qry_cost), INIT);
        chk(int'(resp_port) == 4, "R4 diagonal wins tie", int'(resp_port), 4);
        @(negedge clk);
        chk(resp_valid == 1'b0, "R2 single pulse", int'(resp_valid), 0);
        link_valid = 8'h0F;
        probe(1);
        chk(int'(resp_port) == 0, "R4 lowest straight wins tie", int'(resp_port), 0);
        link_valid = 8'h6C;
        probe(2);
        chk(int'(resp_port) == 5, "R4 lowest diagonal wins tie", int'(resp_port), 5);

        // R6: learning updates, incl. saturating cost
        for (int d = 0; d < 3; d++)
            for (int k = 0; k < 6; k++)
                do_update(d, (d * 3 + k * 5) % NN, (d * 7 + k * 11) % 20);
        do_update(2, 6, 255);
        do_update(1, 2, 0);
        do_update(1, 2, 0);

        // R3/R5/R6/R10 sweep over masks and destinations
        for (int mi = 0; mi < 6; mi++) begin
            link_valid = masks[mi];
            for (int d = 0; d < 3; d++)
                greedy_check(d, "R3 R5 R6 R10 sweep");
        end

        // R7: update and lookup on the same entry in one cycle
        link_valid = 8'h03;
        @(negedge clk);
        upd_valid = 1'b1; upd_dest = 2'd3; upd_port = 3'd1; upd_cost = 8'd0;
        req_valid = 1'b1; req_dest = 2'd3;
        qry_valid = 1'b1; qry_dest = 2'd3;
        @(posedge clk);
        @(negedge clk);
        upd_valid = 1'b0; req_valid = 1'b0; qry_valid = 1'b0;
        mdl_upd(3, 1, 0);
        chk(int'(resp_port) == 1, "R7 updated entry wins", int'(resp_port), 1);
        chk(int'(qry_cost) == 8, "R7 query sees update", int'(qry_cost), 8);

        // R8: exploration on, two usable ports
        link_valid = 8'h24; epsilon = 8'd255;
        mdl_best(0, link_valid, bp, bc, fnd);
        n_expl = 0;
        for (int i = 0; i < 64; i++) begin
            probe(0);
            chk(resp_port == 3'd2 || resp_port == 3'd5, "R5 R8 explored port usable",
                int'(resp_port), 2);
            if (resp_explore) n_expl++;
            else chk(int'(resp_port) == bp, "R8 greedy when not exploring",
                     int'(resp_port), bp);
        end
        chk(n_expl >= 48, "R8 epsilon 255 explores", n_expl, 48);

        link_valid = 8'h08;
        for (int i = 0; i < 8; i++) begin
            probe(1);
            chk(int'(resp_port) == 3, "R5 R8 single link", int'(resp_port), 3);
        end

        link_valid = 8'hFF; epsilon = 8'd0;
        mdl_best(2, link_valid, bp, bc, fnd);
        n_expl = 0;
        for (int i = 0; i < 32; i++) begin
            probe(2);
            if (resp_explore) n_expl++;
            chk(int'(resp_port) == bp, "R8 epsilon 0 greedy", int'(resp_port), bp);
        end
        chk(n_expl == 0, "R8 epsilon 0 never explores", n_expl, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule